// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing front end of an 8K x 8 serial memory. It takes SCL and SDA sampled by a much faster system clock and recognizes Start and Stop conditions. It shifts bytes in and out most significant bit first and pulls SDA low through an open-drain enable. A transfer begins with a control byte. For a write, a two-byte word address follows, and then data that goes to the memory port. For a read, bytes come from an internal address pointer until the master declines one.

The downstream cache and array logic connects through a synchronous memory port: a one-cycle write strobe, or a one-cycle read strobe with data returned in the following cycle. While that logic reports an internal write cycle on `busy_i`, the engine acknowledges nothing, so a master can poll for completion. When the high address byte has its top bit set, the transfer is a configuration command. It is passed byte by byte to a separate configuration port and never touches memory.

Top module: `eep_i2c_slave`

## Requirements
- R1: A control byte is accepted only if bits [7:4] equal 1010 and bits [3:1] equal `sel_i`; bit 0 is R/W (1 = read). Acceptance is signalled by SDA held low during the ninth clock. After a mismatch, SDA stays released until the next Start.
- R2: While `busy_i` is high, no byte is acknowledged, the control byte included. Once `busy_i` is low, the same control byte is acknowledged again.
- R3: A write sends the control byte (R/W = 0), then the high address byte (bits [7:5] = 000, bits [4:0] = address [12:8]), then the low address byte, then data. Each data byte produces one `mem_we_o` pulse carrying that address and data.
- R4: Successive data bytes of one write go to successive addresses. Only address bits [5:0] advance, wrapping inside the 64-byte window, and bits [12:6] hold.
- R5: A read that follows a completed access starts at the last accessed address plus one.
- R6: A repeated Start after the low address byte ends the write phase with the pointer loaded, so the next read starts at that address.
- R7: A master ACK after a read byte returns the next address across the whole 13-bit space, wrapping from 0x1FFF to 0x0000.
- R8: A master NACK after a read byte makes the block release SDA and drive nothing until the next Start.
- R9: A high address byte with bit 7 = 1 is acknowledged and starts a configuration command. That byte, and every later byte up to Start or Stop, is acknowledged and appears once on the configuration port, with `cfg_first_o` marking the first. No memory strobe occurs and the pointer is unchanged.
- R10: A high address byte with bit 7 = 0 and a nonzero bit 6 or 5 is not acknowledged. Neither memory nor pointer is affected.
- R11: A Start or Stop in the middle of a byte discards the partial byte. No write results, and a Start returns the engine to control-byte reception.
- R12: After reset, and whenever the engine is idle, SDA is released. The SDA enable changes only while SCL is low. Memory strobes last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| sel_i | input | 3 | Device select strap value |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_addr_o | output | ADDR_W | Memory address for the current strobe |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_re_o | output | 1 | One-cycle read strobe |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_re_o` |
| cfg_we_o | output | 1 | Configuration byte strobe |
| cfg_first_o | output | 1 | Marks the first byte of a configuration command |
| cfg_data_o | output | 8 | Configuration byte |

## Verification
The assertions rely on a well-formed bus. SDA moves only while SCL is low, except at Start and Stop, and each SCL phase spans enough system clocks to cover the two-stage synchronizer plus the two-cycle read turnaround. They also assume that a master never forms a Start or Stop while the engine holds SDA low. The stimulus keeps to these conditions. It holds every SCL phase for ten system clocks and changes SDA three clocks after SCL falls. All inputs are driven on the falling edge of the system clock, so the SDA enable can only change during SCL low.

// File: rtl/eep_i2c_pkg.sv
package eep_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA, ST_CFG, ST_RDATA
  } st_e;
  localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/eep_i2c_bus_cond.sv
module eep_i2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_o;
      sda_q  <= sda_o;
    end
  end

  assign scl_o      = scl_sr[SYNC_STAGES-1];
  assign sda_o      = sda_sr[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_i2c_addr_ptr.sv
module eep_i2c_addr_ptr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              inc_rd_i,
  input  logic              inc_wr_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else if (ld_i) ptr_o <= ld_val_i;
    else if (inc_rd_i) ptr_o <= ptr_o + 1'b1;
    else if (inc_wr_i) ptr_o <= {ptr_o[ADDR_W-1:PAGE_W], ptr_o[PAGE_W-1:0] + 1'b1};
  end

  assert_wr_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_wr_i && !ld_i) |=> ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_i2c_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        sel_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              cfg_we_o,
  output logic              cfg_first_o,
  output logic [7:0]        cfg_data_o
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, rise, fall, start, stop;
  st_e st;
  logic [3:0] bit_cnt;
  logic ack_ph, slv_ack, rd_p1;
  logic [7:0] rx_sh, tx_sh;
  logic [HI_W-1:0] addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic rx_end, acc, m_ack, rd_issue, wr_issue, ptr_ld, ctrl_hit;

  eep_i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  eep_i2c_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i, .rst_ni, .ld_i(ptr_ld), .ld_val_i({addr_hi, rx_sh}),
    .inc_rd_i(rd_issue), .inc_wr_i(wr_issue), .ptr_o(ptr)
  );

  assign ctrl_hit = (rx_sh[7:4] == CTRL_CODE) && (rx_sh[3:1] == sel_i);
  assign rx_end   = fall && !ack_ph && (bit_cnt == 4'd8) && (st != ST_IDLE) && (st != ST_RDATA);

  always_comb begin
    unique case (st)
      ST_CTRL:                     acc = ctrl_hit;
      ST_ADDR_HI:                  acc = rx_sh[7] || ((rx_sh[6:0] >> HI_W) == 7'd0);
      ST_ADDR_LO, ST_WDATA, ST_CFG: acc = 1'b1;
      default:                     acc = 1'b0;
    endcase
    acc = acc && !busy_i;
  end

  assign m_ack    = rise && ack_ph && (st == ST_RDATA) && !slv_ack && !sda_s;
  assign rd_issue = (rx_end && acc && (st == ST_CTRL) && rx_sh[0]) || m_ack;
  assign wr_issue = rx_end && acc && (st == ST_WDATA);
  assign ptr_ld   = rx_end && acc && (st == ST_ADDR_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; bit_cnt <= '0; ack_ph <= 1'b0; slv_ack <= 1'b0;
      sda_oe_o <= 1'b0; rx_sh <= '0; tx_sh <= '0; addr_hi <= '0; rd_p1 <= 1'b0;
      mem_we_o <= 1'b0; mem_re_o <= 1'b0; mem_addr_o <= '0; mem_wdata_o <= '0;
      cfg_we_o <= 1'b0; cfg_first_o <= 1'b0; cfg_data_o <= '0;
    end else begin
      mem_we_o <= wr_issue;
      mem_re_o <= rd_issue;
      rd_p1    <= mem_re_o;
      cfg_we_o <= 1'b0;
      if (wr_issue || rd_issue) mem_addr_o <= ptr;
      if (wr_issue) mem_wdata_o <= rx_sh;
      if (rd_p1) tx_sh <= mem_rdata_i;

      if (start || stop) begin
        st <= start ? ST_CTRL : ST_IDLE;
        bit_cnt <= '0; ack_ph <= 1'b0; slv_ack <= 1'b0; sda_oe_o <= 1'b0;
      end else if (rise && st != ST_IDLE) begin
        if (!ack_ph) begin
          rx_sh   <= {rx_sh[6:0], sda_s};
          tx_sh   <= {tx_sh[6:0], 1'b0};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (st == ST_RDATA && !slv_ack && sda_s) begin
          st <= ST_IDLE;  // master NACK
        end
      end else if (fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0; slv_ack <= 1'b0; bit_cnt <= '0;
          sda_oe_o <= (st == ST_RDATA) ? ~tx_sh[7] : 1'b0;
        end else if (rx_end) begin
          if (!acc) st <= ST_IDLE;
          else begin
            ack_ph <= 1'b1; slv_ack <= 1'b1; sda_oe_o <= 1'b1;
            unique case (st)
              ST_CTRL: st <= rx_sh[0] ? ST_RDATA : ST_ADDR_HI;
              ST_ADDR_HI: begin
                if (rx_sh[7]) begin
                  st <= ST_CFG; cfg_we_o <= 1'b1; cfg_first_o <= 1'b1; cfg_data_o <= rx_sh;
                end else begin
                  st <= ST_ADDR_LO; addr_hi <= rx_sh[HI_W-1:0];
                end
              end
              ST_ADDR_LO: st <= ST_WDATA;
              ST_CFG: begin
                cfg_we_o <= 1'b1; cfg_first_o <= 1'b0; cfg_data_o <= rx_sh;
              end
              default: ;
            endcase
          end
        end else if (st == ST_RDATA) begin
          if (bit_cnt == 4'd8) begin
            sda_oe_o <= 1'b0; ack_ph <= 1'b1;
          end else begin
            sda_oe_o <= ~tx_sh[7];
          end
        end
      end
    end
  end

  assert_sda_scl_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);
  assert_we_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  assert_re_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);
  assert_busy_noack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slv_ack) |-> !$past(busy_i));
  assert_cfg_nomem_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> !(mem_we_o || mem_re_o));
endmodule

// File: tb/test_eep_i2c_slave.sv
`timescale 1ns/1ps
module test_eep_i2c_slave;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] CR = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe_o, mem_we_o, mem_re_o, cfg_we_o, cfg_first_o;
  logic [12:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata, cfg_data_o;
  wire sda_ln = sda_m & ~sda_oe_o;
  int n_chk = 0, n_fail = 0;
  logic [20:0] wq[$];
  logic [8:0] cq[$];
  logic [7:0] ram[int];
  logic [7:0] ref_w[int];

  always #2 clk = ~clk;

  eep_i2c_slave i_eep_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe_o,
    .sel_i(SEL), .busy_i(busy), .mem_addr_o, .mem_we_o, .mem_wdata_o, .mem_re_o,
    .mem_rdata_i(mem_rdata), .cfg_we_o, .cfg_first_o, .cfg_data_o
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a) ^ {a[12:8], 3'b101};
  endfunction
  function automatic logic [7:0] exp_b(int a);
    return ref_w.exists(a) ? ref_w[a] : pat(a);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory stub
  always @(posedge clk) begin
    if (mem_we_o) ram[int'(mem_addr_o)] = mem_wdata_o;
    if (mem_re_o) mem_rdata <= ram.exists(int'(mem_addr_o)) ? ram[int'(mem_addr_o)] : pat(int'(mem_addr_o));
  end

  // monitor: pops scoreboard queues
  always @(negedge clk) begin
    if (mem_we_o) begin
      if (wq.size() == 0) chk(1'b0, "R3 unexpected memory write", int'(mem_addr_o), 0);
      else begin
        logic [20:0] e;
        e = wq.pop_front();
        chk({mem_addr_o, mem_wdata_o} == e, "R3 R4 write addr/data", int'({mem_addr_o, mem_wdata_o}), int'(e));
      end
    end
    if (cfg_we_o) begin
      if (cq.size() == 0) chk(1'b0, "R9 unexpected cfg byte", int'(cfg_data_o), 0);
      else begin
        logic [8:0] c;
        c = cq.pop_front();
        chk({cfg_first_o, cfg_data_o} == c, "R9 cfg byte", int'({cfg_first_o, cfg_data_o}), int'(c));
      end
    end
  end

  task automatic w(int n); repeat (n) @(negedge clk); endtask
  task automatic bit_x(input logic d, output logic s);
    w(3); sda_m = d; w(7); scl_m = 1'b1; w(5); s = sda_ln; w(5); scl_m = 1'b0;
  endtask
  task automatic m_start();
    w(3); sda_m = 1'b1; w(7); scl_m = 1'b1; w(10); sda_m = 1'b0; w(10); scl_m = 1'b0;
  endtask
  task automatic m_stop();
    w(3); sda_m = 1'b0; w(7); scl_m = 1'b1; w(10); sda_m = 1'b1; w(10);
  endtask
  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = !s;
  endtask
  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); b[i] = s; end
    bit_x(!mack, s);
  endtask
  task automatic set_addr(input logic [12:0] a, string tag);
    logic k;
    m_start;
    wr_byte(CW, k);            chk(k, {tag, " ctrl ack"}, k, 1);
    wr_byte({3'b000, a[12:8]}, k); chk(k, {tag, " addr hi ack"}, k, 1);
    wr_byte(a[7:0], k);        chk(k, {tag, " addr lo ack"}, k, 1);
  endtask
  task automatic rd_chk(input logic mack, input int a, string tag);
    logic [7:0] b;
    rd_byte(mack, b);
    chk(b == exp_b(a), tag, b, exp_b(a));
  endtask
  task automatic cur_read(input int a, string tag);
    logic k;
    m_start;
    wr_byte(CR, k); chk(k, {tag, " read ctrl ack"}, k, 1);
    rd_chk(1'b0, a, tag);
    m_stop;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    w(150000);
    n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic k, s;
    logic [7:0] b;
    w(5); rst_n = 1'b1; w(2);
    chk(!sda_oe_o && !mem_we_o && !mem_re_o && !cfg_we_o, "R12 reset state idle", sda_oe_o, 0);

    // R1: select and code mismatch
    m_start;
    wr_byte({4'b1010, 3'b011, 1'b0}, k); chk(!k, "R1 wrong select not acked", k, 0);
    wr_byte(8'h00, k);                   chk(!k, "R1 released after mismatch", k, 0);
    m_stop;
    m_start;
    wr_byte({4'b1011, SEL, 1'b0}, k);    chk(!k, "R1 wrong code not acked", k, 0);
    m_stop;

    // R3: byte write
    set_addr(13'h0123, "R3");
    wq.push_back({13'h0123, 8'hA5}); ref_w[13'h0123] = 8'hA5;
    wr_byte(8'hA5, k); chk(k, "R3 data ack", k, 1);
    m_stop;

    // R2: busy blocks acknowledge
    busy = 1'b1;
    m_start; wr_byte(CW, k); chk(!k, "R2 no ack while busy", k, 0); m_stop;
    busy = 1'b0;
    m_start; wr_byte(CW, k); chk(k, "R2 ack after busy clears", k, 1); m_stop;

    // R5: current address read
    cur_read(13'h0124, "R5 current read");

    // R6/R7: random then sequential read with wrap
    set_addr(13'h1FFE, "R6");
    m_start; wr_byte(CR, k); chk(k, "R6 read ctrl ack", k, 1);
    rd_chk(1'b1, 13'h1FFE, "R6 random read");
    rd_chk(1'b1, 13'h1FFF, "R7 sequential next");
    rd_chk(1'b0, 13'h0000, "R7 wrap to zero");
    // R8: after NACK nothing is driven
    rd_byte(1'b0, b); chk(b == 8'hFF, "R8 released after NACK", b, 8'hFF);
    m_stop;
    cur_read(13'h0001, "R5 pointer after wrap");

    // R4: page write wraps inside 64-byte window
    set_addr(13'h0A3C, "R4");
    for (int i = 0; i < 6; i++) begin
      logic [12:0] a;
      a = {7'(13'h0A3C >> 6), 6'(6'h3C + i)};
      wq.push_back({a, 8'(8'h10 + i)}); ref_w[int'(a)] = 8'(8'h10 + i);
      wr_byte(8'(8'h10 + i), k); chk(k, "R4 page data ack", k, 1);
    end
    m_stop;
    set_addr(13'h0A00, "R4");
    m_start; wr_byte(CR, k); chk(k, "R4 readback ctrl ack", k, 1);
    rd_chk(1'b1, 13'h0A00, "R4 wrapped byte 4");
    rd_chk(1'b0, 13'h0A01, "R4 wrapped byte 5");
    m_stop;
    set_addr(13'h0A3F, "R7");
    m_start; wr_byte(CR, k); chk(k, "R7 ctrl ack", k, 1);
    rd_chk(1'b1, 13'h0A3F, "R4 last in window");
    rd_chk(1'b0, 13'h0A40, "R7 read crosses window");
    m_stop;

    // R9: configuration command
    cq.push_back({1'b1, 8'h8A}); cq.push_back({1'b0, 8'h00}); cq.push_back({1'b0, 8'hA3});
    m_start;
    wr_byte(CW, k);    chk(k, "R9 ctrl ack", k, 1);
    wr_byte(8'h8A, k); chk(k, "R9 cfg hi ack", k, 1);
    wr_byte(8'h00, k); chk(k, "R9 cfg byte ack", k, 1);
    wr_byte(8'hA3, k); chk(k, "R9 cfg byte ack", k, 1);
    m_stop;
    cur_read(13'h0A41, "R9 pointer unchanged");

    // R10: reserved high bits
    m_start;
    wr_byte(CW, k);    chk(k, "R10 ctrl ack", k, 1);
    wr_byte(8'h40, k); chk(!k, "R10 reserved bits not acked", k, 0);
    m_stop;
    cur_read(13'h0A42, "R10 pointer unchanged");

    // R11: aborts
    set_addr(13'h0200, "R11");
    bit_x(1'b1, s); bit_x(1'b0, s); bit_x(1'b1, s); bit_x(1'b0, s);
    m_stop;
    cur_read(13'h0200, "R11 stop abort no write");
    m_start;
    bit_x(CW[7], s); bit_x(CW[6], s); bit_x(CW[5], s);
    m_start;
    wr_byte(CR, k); chk(k, "R11 start abort ctrl ack", k, 1);
    rd_chk(1'b0, 13'h0201, "R11 start abort read");
    m_stop;

    w(50);
    chk(wq.size() == 0, "R3 all writes seen", wq.size(), 0);
    chk(cq.size() == 0, "R9 all cfg bytes seen", cq.size(), 0);
    chk(!sda_oe_o, "R12 idle released", sda_oe_o, 0);
    summary();
    $finish;
  end
endmodule